// File: doc/BRIEF.md
# Banked GPIO Register Block with Half-Word Masked Writes

This block is a register-mapped general-purpose I/O controller organised as four banks of up to 32 pins. Software reaches it through a single-cycle 32-bit register port: a write takes effect on the clock edge where it is presented, and read data follows the address combinationally in the same cycle. Each bank holds its output levels, a direction word and an output-enable word, all driven onto plain vector ports. Each bank also exposes its pin levels after a two-flop synchronizer, plus a set of interrupt configuration words that are held as plain storage.

Output levels are changed through two write-only words per bank. One covers pins 0 to 15 and the other covers pins 16 to 31. The upper sixteen bits of such a word are an active-low mask and the lower sixteen are the new levels. A single access can therefore set or clear any subset of sixteen pins without reading first. Banks may have fewer than 32 pins, and bit positions beyond a bank's pin count are absent. Two pins of bank 0 are hard-wired as outputs.

Top module: `bankgpio_ctrl`

## Requirements
- R1: After reset every output level and every output enable is 0. Every direction bit is 0 except the two forced ones. Every implemented interrupt-mask bit reads 1, meaning masked.
- R2: A write to byte address 8×bank (low half word) updates output pin n, for n = 0..15, to data bit n (wdata[n]) only where mask bit wdata[16+n] is 0. Pins whose mask bit is 1 keep their level. Without such a write, no output level changes.
- R3: A write to byte address 4 + 8×bank (high half word) applies the same rule to pins 16..31. Data bit wdata[n] drives pin n+16 when mask bit wdata[16+n] is 0.
- R4: A read of address 0x060 + 4×bank returns that bank's pin_in levels as they were two rising clock edges earlier.
- R5: Direction (0x204 + 0x40×bank) and output enable (0x208 + 0x40×bank) are read/write. Each bit drives pin_dir and pin_oe directly, and 1 means output or enabled.
- R6: Banks have 32, 22, 32 and 32 pins. In every register, bits at or above a bank's pin count read 0, ignore writes, and hold their pin_out, pin_oe and pin_dir bits at 0.
- R7: Bank 0 bits 7 and 8 of the direction register always read 1 and always drive pin_dir 1, whatever is written to them.
- R8: For the interrupt mask (read-only, 0x20C + 0x40×bank), writing 1s to the enable word (0x210 + 0x40×bank) clears the matching mask bits. Writing 1s to the disable word (0x214 + 0x40×bank) sets them, so writing 0xFFFFFFFF masks the whole bank.
- R9: Interrupt status (0x218), type (0x21C), polarity (0x220) and any-edge (0x224), each plus 0x40×bank, are read/write storage.
- R10: Reads of write-only words (the half-word output words, interrupt enable and interrupt disable) and of unmapped addresses return 0. Writes to the read-only words (pin levels and interrupt mask) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (10) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_in | input | NBANK×32 (128) | Raw pin levels, bank b at bits 32b+31:32b |
| pin_out | output | NBANK×32 (128) | Output levels |
| pin_oe | output | NBANK×32 (128) | Output enables |
| pin_dir | output | NBANK×32 (128) | Direction, 1 = output |

## Verification
The bench builds the block with its default parameters: four banks of 32, 22, 32 and 32 pins, and bank 0 bits 7 and 8 forced to output. These values bring the ten dead high bits of the narrow bank within reach, through pin_out, pin_dir, pin_oe, the mask word and the storage words. They also exercise the forced direction bits against writes of both 0 and 1. Masked half-word writes are driven with partial masks on both halves, and the synchronizer's two-edge latency is observed one edge at a time.

// File: rtl/bankgpio_pkg.sv
package bankgpio_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned CNT_W  = 6;

  // byte offsets of the per-bank registers
  localparam int unsigned OFS_MD_LO  = 'h000;
  localparam int unsigned OFS_MD_HI  = 'h004;
  localparam int unsigned MD_STRIDE  = 'h008;
  localparam int unsigned OFS_PINVAL = 'h060;
  localparam int unsigned PV_STRIDE  = 'h004;
  localparam int unsigned OFS_DIR    = 'h204;
  localparam int unsigned OFS_OE     = 'h208;
  localparam int unsigned OFS_IMASK  = 'h20C;
  localparam int unsigned OFS_IEN    = 'h210;
  localparam int unsigned OFS_IDIS   = 'h214;
  localparam int unsigned OFS_ISTAT  = 'h218;
  localparam int unsigned OFS_ITYPE  = 'h21C;
  localparam int unsigned OFS_IPOL   = 'h220;
  localparam int unsigned OFS_IANY   = 'h224;
  localparam int unsigned CFG_STRIDE = 'h040;

  typedef struct packed {
    logic md_lo;
    logic md_hi;
    logic dir;
    logic oe;
    logic ien;
    logic idis;
    logic istat;
    logic itype;
    logic ipol;
    logic iany;
  } bank_wr_t;

  typedef struct packed {
    logic pinval;
    logic dir;
    logic oe;
    logic imask;
    logic istat;
    logic itype;
    logic ipol;
    logic iany;
  } bank_rd_t;

  function automatic logic [WORD_W-1:0] valid_mask(input int unsigned pins);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (i < int'(pins)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/bankgpio_rst_sync.sv
module bankgpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/bankgpio_sync.sv
module bankgpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/bankgpio_dec.sv
module bankgpio_dec
  import bankgpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BANK   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output bank_wr_t          wr_o,
  output bank_rd_t          rd_o
);

  localparam logic [ADDR_W-1:0] A_MD_LO = ADDR_W'(OFS_MD_LO + MD_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_MD_HI = ADDR_W'(OFS_MD_HI + MD_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_PV    = ADDR_W'(OFS_PINVAL + PV_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'(OFS_IMASK + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(OFS_IDIS + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_ISTA  = ADDR_W'(OFS_ISTAT + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_ITYP  = ADDR_W'(OFS_ITYPE + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_IPOL  = ADDR_W'(OFS_IPOL + CFG_STRIDE * BANK);
  localparam logic [ADDR_W-1:0] A_IANY  = ADDR_W'(OFS_IANY + CFG_STRIDE * BANK);

  always_comb begin
    wr_o.md_lo = wr && (addr == A_MD_LO);
    wr_o.md_hi = wr && (addr == A_MD_HI);
    wr_o.dir   = wr && (addr == A_DIR);
    wr_o.oe    = wr && (addr == A_OE);
    wr_o.ien   = wr && (addr == A_IEN);
    wr_o.idis  = wr && (addr == A_IDIS);
    wr_o.istat = wr && (addr == A_ISTA);
    wr_o.itype = wr && (addr == A_ITYP);
    wr_o.ipol  = wr && (addr == A_IPOL);
    wr_o.iany  = wr && (addr == A_IANY);

    rd_o.pinval = (addr == A_PV);
    rd_o.dir    = (addr == A_DIR);
    rd_o.oe     = (addr == A_OE);
    rd_o.imask  = (addr == A_IMSK);
    rd_o.istat  = (addr == A_ISTA);
    rd_o.itype  = (addr == A_ITYP);
    rd_o.ipol   = (addr == A_IPOL);
    rd_o.iany   = (addr == A_IANY);
  end

endmodule

// File: rtl/bankgpio_bank.sv
module bankgpio_bank
  import bankgpio_pkg::*;
#(
  parameter int unsigned       PINS      = 32,
  parameter logic [WORD_W-1:0] FORCE_OUT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_wr_t          wr,
  input  bank_rd_t          rd,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] pin_lvl,
  output logic [WORD_W-1:0] out_o,
  output logic [WORD_W-1:0] oe_o,
  output logic [WORD_W-1:0] dir_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam logic [WORD_W-1:0] VALID = valid_mask(PINS);

  logic [WORD_W-1:0] out_q, out_d;
  logic [WORD_W-1:0] dir_q, oe_q;
  logic [WORD_W-1:0] imask_q, imask_d;
  logic [WORD_W-1:0] istat_q, itype_q, ipol_q, iany_q;
  logic [WORD_W-1:0] cfg_d;
  logic [WORD_W-1:0] keep_lo, keep_hi, put_lo, put_hi;
  logic              out_en, imask_en;

  // next-state
  always_comb begin
    keep_lo = {{HALF_W{1'b1}}, wdata[WORD_W-1:HALF_W]};
    put_lo  = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
    keep_hi = {wdata[WORD_W-1:HALF_W], {HALF_W{1'b1}}};
    put_hi  = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};

    out_en = wr.md_lo || wr.md_hi;
    if (wr.md_lo) begin
      out_d = (out_q & keep_lo) | (put_lo & ~keep_lo);
    end else if (wr.md_hi) begin
      out_d = (out_q & keep_hi) | (put_hi & ~keep_hi);
    end else begin
      out_d = out_q;
    end
    out_d = out_d & VALID;

    imask_en = wr.ien || wr.idis;
    if (wr.ien) begin
      imask_d = imask_q & ~wdata;
    end else if (wr.idis) begin
      imask_d = imask_q | wdata;
    end else begin
      imask_d = imask_q;
    end
    imask_d = imask_d & VALID;

    cfg_d = wdata & VALID;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      oe_q    <= '0;
      imask_q <= VALID;
      istat_q <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
      iany_q  <= '0;
    end else begin
      if (out_en)    out_q   <= out_d;
      if (wr.dir)    dir_q   <= cfg_d;
      if (wr.oe)     oe_q    <= cfg_d;
      if (imask_en)  imask_q <= imask_d;
      if (wr.istat)  istat_q <= cfg_d;
      if (wr.itype)  itype_q <= cfg_d;
      if (wr.ipol)   ipol_q  <= cfg_d;
      if (wr.iany)   iany_q  <= cfg_d;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;
  assign dir_o = (dir_q | FORCE_OUT) & VALID;

  // read selection
  always_comb begin
    rdata_o = '0;
    if (rd.pinval) rdata_o = rdata_o | (pin_lvl & VALID);
    if (rd.dir)    rdata_o = rdata_o | dir_o;
    if (rd.oe)     rdata_o = rdata_o | oe_q;
    if (rd.imask)  rdata_o = rdata_o | imask_q;
    if (rd.istat)  rdata_o = rdata_o | istat_q;
    if (rd.itype)  rdata_o = rdata_o | itype_q;
    if (rd.ipol)   rdata_o = rdata_o | ipol_q;
    if (rd.iany)   rdata_o = rdata_o | iany_q;
  end

endmodule

// File: rtl/bankgpio_ctrl.sv
module bankgpio_ctrl
  import bankgpio_pkg::*;
#(
  parameter int unsigned                   NBANK           = 4,
  parameter int unsigned                   ADDR_W          = 10,
  parameter logic [NBANK*CNT_W-1:0]        BANK_PINS       = {6'd32, 6'd32, 6'd22, 6'd32},
  parameter logic [WORD_W-1:0]             BANK0_FORCE_OUT = 32'h0000_0180,
  localparam int unsigned                  PIN_W           = NBANK * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_dir
);

  logic              rst_sync_n;
  logic [PIN_W-1:0]  pin_lvl;
  logic [WORD_W-1:0] rd_bank [NBANK];

  bankgpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bankgpio_sync #(.W(PIN_W)) u_insync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (pin_lvl)
  );

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    localparam int unsigned       PINS_B  = int'(BANK_PINS[b*CNT_W +: CNT_W]);
    localparam logic [WORD_W-1:0] FORCE_B = (b == 0) ? BANK0_FORCE_OUT : '0;

    bank_wr_t wr_sel;
    bank_rd_t rd_sel;

    bankgpio_dec #(.ADDR_W(ADDR_W), .BANK(b)) u_dec (
      .addr (bus_addr),
      .wr   (bus_wr),
      .wr_o (wr_sel),
      .rd_o (rd_sel)
    );

    bankgpio_bank #(.PINS(PINS_B), .FORCE_OUT(FORCE_B)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr      (wr_sel),
      .rd      (rd_sel),
      .wdata   (bus_wdata),
      .pin_lvl (pin_lvl[b*WORD_W +: WORD_W]),
      .out_o   (pin_out[b*WORD_W +: WORD_W]),
      .oe_o    (pin_oe[b*WORD_W +: WORD_W]),
      .dir_o   (pin_dir[b*WORD_W +: WORD_W]),
      .rdata_o (rd_bank[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(NBANK); b++) begin
      bus_rdata = bus_rdata | rd_bank[b];
    end
  end

endmodule

// File: rtl/bankgpio_ctrl_chk.sv
module bankgpio_ctrl_chk
  import bankgpio_pkg::*;
#(
  parameter int unsigned            NBANK           = 4,
  parameter int unsigned            ADDR_W          = 10,
  parameter logic [NBANK*CNT_W-1:0] BANK_PINS       = {6'd32, 6'd32, 6'd22, 6'd32},
  parameter logic [WORD_W-1:0]      BANK0_FORCE_OUT = 32'h0000_0180,
  localparam int unsigned           PIN_W           = NBANK * WORD_W
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pin_in,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe,
  input logic [PIN_W-1:0]  pin_dir
);

  function automatic logic [PIN_W-1:0] all_valid();
    logic [PIN_W-1:0] v;
    v = '0;
    for (int b = 0; b < int'(NBANK); b++) begin
      v[b*WORD_W +: WORD_W] = valid_mask(int'(BANK_PINS[b*CNT_W +: CNT_W]));
    end
    return v;
  endfunction

  localparam logic [PIN_W-1:0] VALID_ALL = all_valid();
  localparam logic [WORD_W-1:0] VALID0   = valid_mask(int'(BANK_PINS[CNT_W-1:0]));

  logic [1:0] age_q;
  logic       md_hit;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign md_hit = bus_wr && (bus_addr[1:0] == 2'b00) &&
                  (int'(bus_addr) < int'(MD_STRIDE * NBANK));

  AST_FORCED_DIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((pin_dir[WORD_W-1:0] & BANK0_FORCE_OUT & VALID0) == (BANK0_FORCE_OUT & VALID0))); // R7

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((pin_out | pin_oe | pin_dir) & ~VALID_ALL) == '0)); // R6

  AST_LO_MERGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_MD_LO)) |=>
      (pin_out[HALF_W-1:0] ==
        (($past(pin_out[HALF_W-1:0]) & $past(bus_wdata[WORD_W-1:HALF_W])) |
         ($past(bus_wdata[HALF_W-1:0]) & ~$past(bus_wdata[WORD_W-1:HALF_W]))))); // R2

  AST_HI_MERGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_MD_HI)) |=>
      (pin_out[WORD_W-1:HALF_W] ==
        (($past(pin_out[WORD_W-1:HALF_W]) & $past(bus_wdata[WORD_W-1:HALF_W])) |
         ($past(bus_wdata[HALF_W-1:0]) & ~$past(bus_wdata[WORD_W-1:HALF_W]))))); // R3

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!md_hit) |=> $stable(pin_out)); // R2

  AST_PINVAL_LAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (age_q >= 2'd2 && bus_addr == ADDR_W'(OFS_PINVAL)) |->
      (bus_rdata == ($past(pin_in[WORD_W-1:0], 2) & VALID0))); // R4

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == ADDR_W'(OFS_MD_LO) || bus_addr == ADDR_W'(OFS_IEN) ||
     bus_addr == ADDR_W'(OFS_IDIS)) |-> (bus_rdata == '0)); // R10

endmodule

bind bankgpio_ctrl bankgpio_ctrl_chk #(
  .NBANK           (NBANK),
  .ADDR_W          (ADDR_W),
  .BANK_PINS       (BANK_PINS),
  .BANK0_FORCE_OUT (BANK0_FORCE_OUT)
) chk_i (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_dir   (pin_dir)
);

// File: tb/bankgpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module bankgpio_ctrl_tb_top;

  logic         clk;
  logic         rst_n;
  logic         bus_wr;
  logic [9:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in;
  logic [127:0] pin_out;
  logic [127:0] pin_oe;
  logic [127:0] pin_dir;

  int n_vec;
  int n_bad;
  bit done;

  bankgpio_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_dir   (pin_dir)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_addr  = 10'h3FC;
  endtask

  task automatic reg_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64] | pin_out[127:96], 32'h0);
    check("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64] | pin_oe[127:96], 32'h0);
    check("R1 R7 pin_dir bank0", pin_dir[31:0], 32'h0000_0180);
    check("R1 pin_dir others", pin_dir[63:32] | pin_dir[95:64] | pin_dir[127:96], 32'h0);
    reg_rd(10'h20C, v); check("R1 imask bank0", v, 32'hFFFF_FFFF);
    reg_rd(10'h24C, v); check("R1 R6 imask bank1", v, 32'h003F_FFFF);
  endtask

  task automatic t_low_half;
    reg_wr(10'h000, 32'h0000_A5A5);
    check("R2 full low write", pin_out[31:0], 32'h0000_A5A5);
    reg_wr(10'h000, 32'hFF00_0000);
    check("R2 partial mask", pin_out[31:0], 32'h0000_A500);
    reg_wr(10'h010, 32'h0000_1234);
    check("R2 bank2 low", pin_out[95:64], 32'h0000_1234);
    check("R2 bank0 untouched", pin_out[31:0], 32'h0000_A500);
  endtask

  task automatic t_high_half;
    reg_wr(10'h004, 32'h0F0F_FFFF);
    check("R3 high partial", pin_out[31:0], 32'hF0F0_A500);
    reg_wr(10'h00C, 32'h0000_FFFF);
    check("R3 R6 bank1 high", pin_out[63:32], 32'h003F_0000);
  endtask

  task automatic t_dir_oe;
    logic [31:0] v;
    reg_wr(10'h204, 32'h0000_00FF);
    check("R5 R7 dir pins", pin_dir[31:0], 32'h0000_01FF);
    reg_rd(10'h204, v); check("R5 dir readback", v, 32'h0000_01FF);
    reg_wr(10'h204, 32'h0000_0000);
    reg_rd(10'h204, v); check("R7 forced after zero", v, 32'h0000_0180);
    reg_wr(10'h244, 32'hFFFF_FFFF);
    reg_rd(10'h244, v); check("R6 bank1 dir", v, 32'h003F_FFFF);
    check("R6 bank1 pin_dir", pin_dir[63:32], 32'h003F_FFFF);
    reg_wr(10'h2C8, 32'hDEAD_BEEF);
    reg_rd(10'h2C8, v); check("R5 bank3 oe readback", v, 32'hDEAD_BEEF);
    check("R5 bank3 pin_oe", pin_oe[127:96], 32'hDEAD_BEEF);
  endtask

  task automatic t_pin_read;
    logic [31:0] v;
    @(negedge clk);
    pin_in[95:64] = 32'h1357_9BDF;
    pin_in[63:32] = 32'hFFFF_FFFF;
    reg_rd(10'h068, v); check("R4 one edge old", v, 32'h0);
    reg_rd(10'h068, v); check("R4 two edges new", v, 32'h1357_9BDF);
    reg_rd(10'h064, v); check("R6 bank1 pin levels", v, 32'h003F_FFFF);
  endtask

  task automatic t_irq_mask;
    logic [31:0] v;
    reg_wr(10'h210, 32'h0000_000F);
    reg_rd(10'h20C, v); check("R8 enable clears", v, 32'hFFFF_FFF0);
    reg_wr(10'h214, 32'h0000_0003);
    reg_rd(10'h20C, v); check("R8 disable sets", v, 32'hFFFF_FFF3);
    reg_wr(10'h214, 32'hFFFF_FFFF);
    reg_rd(10'h20C, v); check("R8 disable all", v, 32'hFFFF_FFFF);
    reg_wr(10'h250, 32'hFFFF_FFFF);
    reg_rd(10'h24C, v); check("R8 bank1 enable all", v, 32'h0);
  endtask

  task automatic t_storage;
    logic [31:0] v;
    reg_wr(10'h2D8, 32'h1111_2222);
    reg_wr(10'h2DC, 32'h0F0F_0F0F);
    reg_wr(10'h2E0, 32'hA0A0_5050);
    reg_wr(10'h2E4, 32'h8000_0001);
    reg_rd(10'h2D8, v); check("R9 status", v, 32'h1111_2222);
    reg_rd(10'h2DC, v); check("R9 type", v, 32'h0F0F_0F0F);
    reg_rd(10'h2E0, v); check("R9 polarity", v, 32'hA0A0_5050);
    reg_rd(10'h2E4, v); check("R9 any edge", v, 32'h8000_0001);
    reg_wr(10'h25C, 32'hFFFF_FFFF);
    reg_rd(10'h25C, v); check("R9 R6 bank1 type", v, 32'h003F_FFFF);
  endtask

  task automatic t_read_zero;
    logic [31:0] v;
    reg_rd(10'h000, v); check("R10 low word reads 0", v, 32'h0);
    reg_rd(10'h004, v); check("R10 high word reads 0", v, 32'h0);
    reg_rd(10'h210, v); check("R10 enable reads 0", v, 32'h0);
    reg_rd(10'h214, v); check("R10 disable reads 0", v, 32'h0);
    reg_rd(10'h200, v); check("R10 unmapped 200", v, 32'h0);
    reg_rd(10'h300, v); check("R10 unmapped 300", v, 32'h0);
    reg_wr(10'h060, 32'hFFFF_FFFF);
    reg_rd(10'h060, v); check("R10 pin level write ignored", v, 32'h0);
    reg_wr(10'h20C, 32'h0000_0000);
    reg_rd(10'h20C, v); check("R10 mask write ignored", v, 32'hFFFF_FFFF);
    check("R10 outputs unaffected", pin_out[31:0], 32'hF0F0_A500);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec     = 0;
    n_bad     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = 10'h3FC;
    bus_wdata = '0;
    pin_in    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_low_half;
    t_high_half;
    t_dir_oe;
    t_pin_read;
    t_irq_mask;
    t_storage;
    t_read_zero;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule